// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two independent down-counters behind a small synchronous register port. Each channel counts on a tick. The tick comes either from an external reference strobe or from a shared prescaler that divides the system clock by a power of two. When a counter is at zero and a tick arrives, the channel expires. An auto-reload channel then copies its reload register back into the counter. A one-shot channel parks at zero.

Every expiry sets a sticky event flag, and the flag level drives that channel's interrupt line. Software clears a flag by writing a word that has a zero in the flag's bit position. Bits written as one leave their flags alone, so one channel can be acknowledged without disturbing the other.

Typical uses are a periodic tick, a one-shot deadline, and a free-running timestamp. For the timestamp, the all-ones value is loaded into both the counter and the reload register, and the inverted count is read. A system that needs one timer set per processor places one copy of the block for each.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset every register reads zero, both interrupt lines are low and neither channel counts.
- R2: The control word sits at byte offset 0x00. Channel 0 uses bit 0 (run), bit 1 (auto-reload), bit 11 (reference tick select) and bits 19..21 (prescale exponent). Channel 1 uses bit 2, bit 3, bit 12 and bits 22..24. All other control bits read zero, so writing all ones reads back 0x01F8180F.
- R3: With the reference select at zero, a channel ticks once every 2^n system cycles, where n is its prescale exponent. With the select at one, it ticks once for each cycle in which the reference strobe input is high.
- R4: A running auto-reload channel decrements on each tick. On a tick at zero it reloads and expires, so a reload value of N-1 gives one expiry every N ticks. Reload registers are at 0x10 (channel 0) and 0x18 (channel 1).
- R5: The status word at 0x04 holds the channel 0 flag in bit 0 and the channel 1 flag in bit 8. Writing a zero to a flag bit clears that flag, and writing a one leaves it unchanged. If an expiry and a clear happen in the same cycle, the flag ends up set.
- R6: A running one-shot channel counts down from the value written and expires once on the tick at zero. It then holds zero and raises no further event until its value register is written again.
- R7: With 0xFFFFFFFF in both the value and the reload register, auto-reload on and prescale 0, the bitwise inverse of the value register rises by one per cycle.
- R8: Value registers are at 0x14 (channel 0) and 0x1C (channel 1) and can be read or written at any time. A write takes priority over a decrement or reload in the same cycle, and the written value is read back on the next cycle.
- R9: Interrupt line i equals the level of status flag i on every cycle.
- R10: A channel whose run bit is clear keeps its counter unchanged and raises no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Single-cycle reference tick strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for bus_addr_i, combinational |
| irq_o | output | 2 | Per-channel interrupt, the level of its event flag |

## Verification
On every cycle, the assertions check the local rules:
- a tick on a nonzero running counter takes exactly one off;
- a written value lands on the next cycle;
- a stopped channel or a parked one-shot channel keeps its count;
- a flag rises after each expiry, stays set until a zero is written to its bit, and never rises without an expiry.

Only the bench scenarios can show the end-to-end properties: the reload period measured over whole intervals, the scaling by the prescale exponent, that a one-shot channel stays silent after many more reference ticks, the timestamp slope, the control read-back mask, and that a flag set coinciding with a clear wins. The behavioural reference model compares the read data and the interrupt lines against the design on every cycle.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NUM_CH = 2;

  localparam int CTRL_OFF = 'h00;
  localparam int STAT_OFF = 'h04;

  function automatic int run_pos(input int ch);
    return 2 * ch;
  endfunction

  function automatic int arl_pos(input int ch);
    return 2 * ch + 1;
  endfunction

  function automatic int src_pos(input int ch);
    return 11 + ch;
  endfunction

  function automatic int div_pos(input int ch);
    return 19 + 3 * ch;
  endfunction

  function automatic int flag_pos(input int ch);
    return 8 * ch;
  endfunction

  function automatic int reload_off(input int ch);
    return 'h10 + 8 * ch;
  endfunction

  function automatic int value_off(input int ch);
    return 'h14 + 8 * ch;
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int PRESC_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  output logic [2**PRESC_W-1:0]   tap_o
);
  localparam int NTAP = 2 ** PRESC_W;
  localparam int PC_W = (NTAP > 1) ? NTAP - 1 : 1;

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_q + 1'b1;
  end

  // tap k fires on the last cycle of every block of 2^k cycles
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (k == 0) begin : g_every
      assign tap_o[k] = 1'b1;
    end else begin : g_div
      assign tap_o[k] = &pc_q[k-1:0];
    end
  end
endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             autoreload_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  // count that follows a tick: decrement, reload at zero, or park at zero
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] rel,
    input logic             ar
  );
    if (cur != '0) return cur - 1'b1;
    else if (ar)   return rel;
    else           return '0;
  endfunction

  assign expire_o = tick_i & run_i & ~load_i & (cnt_q == '0) & (autoreload_i | armed_q);
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (load_i)               cnt_q <= load_val_i;
      else if (tick_i && run_i) cnt_q <= step_count(cnt_q, reload_val_i, autoreload_i);

      if (load_i)        armed_q <= 1'b1;
      else if (expire_o) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer #(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 6,
  parameter int PRESC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic [1:0]        irq_o
);
  import dct_pkg::*;

  localparam int NCH  = NUM_CH;
  localparam int NTAP = 2 ** PRESC_W;

  function automatic logic [CNT_W-1:0] ctrl_mask();
    logic [CNT_W-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[run_pos(c)] = 1'b1;
      m[arl_pos(c)] = 1'b1;
      m[src_pos(c)] = 1'b1;
      for (int b = 0; b < PRESC_W; b++) m[div_pos(c) + b] = 1'b1;
    end
    return m;
  endfunction

  logic [CNT_W-1:0]          ctrl_q;
  logic [NCH-1:0]            flag_q;
  logic [NCH-1:0][CNT_W-1:0] reload_q;
  logic [NCH-1:0][CNT_W-1:0] cnt_w;
  logic [NCH-1:0]            tick_w, expire_w, run_w, arl_w, val_wr_w, stat_clr_w;
  logic [NTAP-1:0]           tap_w;
  logic                      ctrl_we, stat_we;

  assign ctrl_we = bus_we_i && (bus_addr_i == ADDR_W'(CTRL_OFF));
  assign stat_we = bus_we_i && (bus_addr_i == ADDR_W'(STAT_OFF));

  dct_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_o  (tap_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata_i & ctrl_mask();
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [PRESC_W-1:0] div_sel;

    assign run_w[g]      = ctrl_q[run_pos(g)];
    assign arl_w[g]      = ctrl_q[arl_pos(g)];
    assign div_sel       = ctrl_q[div_pos(g) +: PRESC_W];
    assign tick_w[g]     = ctrl_q[src_pos(g)] ? ref_tick_i : tap_w[div_sel];
    assign val_wr_w[g]   = bus_we_i && (bus_addr_i == ADDR_W'(value_off(g)));
    assign stat_clr_w[g] = stat_we && !bus_wdata_i[flag_pos(g)];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reload_q[g] <= '0;
      else if (bus_we_i && (bus_addr_i == ADDR_W'(reload_off(g)))) reload_q[g] <= bus_wdata_i;
    end

    // a fresh expiry beats a software clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            flag_q[g] <= 1'b0;
      else if (expire_w[g])   flag_q[g] <= 1'b1;
      else if (stat_clr_w[g]) flag_q[g] <= 1'b0;
    end

    dct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick_w[g]),
      .run_i        (run_w[g]),
      .autoreload_i (arl_w[g]),
      .load_i       (val_wr_w[g]),
      .load_val_i   (bus_wdata_i),
      .reload_val_i (reload_q[g]),
      .count_o      (cnt_w[g]),
      .expire_o     (expire_w[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(CTRL_OFF)) bus_rdata_o = ctrl_q;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr_i == ADDR_W'(STAT_OFF))      bus_rdata_o[flag_pos(c)] = flag_q[c];
      if (bus_addr_i == ADDR_W'(reload_off(c))) bus_rdata_o = reload_q[c];
      if (bus_addr_i == ADDR_W'(value_off(c)))  bus_rdata_o = cnt_w[c];
    end
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int CNT_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [CNT_W-1:0]      bus_wdata_i,
  input logic [1:0]            irq_o,
  input logic [1:0]            tick_w,
  input logic [1:0]            run_w,
  input logic [1:0]            arl_w,
  input logic [1:0]            val_wr_w,
  input logic [1:0]            expire_w,
  input logic [1:0]            stat_clr_w,
  input logic [1:0][CNT_W-1:0] cnt_w
);
  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_TICK_DECREMENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_w[g] && run_w[g] && cnt_w[g] != '0 && !val_wr_w[g] |=> cnt_w[g] == $past(cnt_w[g]) - 1'b1); // R3
    AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_w[g] |=> irq_o[g]); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] && !stat_clr_w[g] |=> irq_o[g]); // R5
    AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o[g] && !expire_w[g] |=> !irq_o[g]); // R9
    AST_ONESHOT_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_w[g] && !arl_w[g] && cnt_w[g] == '0 && !val_wr_w[g] |=> cnt_w[g] == '0); // R6
    AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      val_wr_w[g] |=> cnt_w[g] == $past(bus_wdata_i)); // R8
    AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_w[g] && !val_wr_w[g] |=> $stable(cnt_w[g])); // R10
  end
endmodule

bind dual_countdown_timer dct_checker #(.CNT_W(CNT_W)) u_dct_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .tick_w      (tick_w),
  .run_w       (run_w),
  .arl_w       (arl_w),
  .val_wr_w    (val_wr_w),
  .expire_w    (expire_w),
  .stat_clr_w  (stat_clr_w),
  .cnt_w       (cnt_w)
);

// File: tb/dual_countdown_timer_tb_top.sv
module dual_countdown_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_countdown_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_tick_i  (ref_tick),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // behavioural reference model
  logic [31:0] m_ctrl;
  logic [31:0] m_rel [2];
  logic [31:0] m_val [2];
  bit          m_arm [2];
  bit          m_flag[2];
  int          m_pc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_pc = 0;
      for (int i = 0; i < 2; i++) begin
        m_rel[i] = '0; m_val[i] = '0; m_arm[i] = 0; m_flag[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        int n; bit tk, wv, ex;
        n  = int'(m_ctrl[19+3*i +: 3]);
        tk = m_ctrl[11+i] ? ref_tick : ((m_pc % (1 << n)) == (1 << n) - 1);
        wv = we && (int'(addr) == 'h14 + 8*i);
        ex = tk && m_ctrl[2*i] && m_val[i] == 0 && (m_ctrl[2*i+1] || m_arm[i]) && !wv;
        if (wv) begin
          m_val[i] = wdata; m_arm[i] = 1;
        end else if (tk && m_ctrl[2*i]) begin
          if (m_val[i] != 0)        m_val[i] = m_val[i] - 1;
          else if (m_ctrl[2*i+1])   m_val[i] = m_rel[i];
        end
        if (ex) begin
          m_arm[i] = 0; m_flag[i] = 1;
        end else if (we && addr == 6'h04 && !wdata[8*i]) begin
          m_flag[i] = 0;
        end
      end
      if (we && addr == 6'h00) m_ctrl = wdata & 32'h01F8180F;
      if (we && addr == 6'h10) m_rel[0] = wdata;
      if (we && addr == 6'h18) m_rel[1] = wdata;
      m_pc++;
    end
  end

  function automatic logic [31:0] mread(input logic [5:0] a);
    case (a)
      6'h00:   return m_ctrl;
      6'h04:   return {23'b0, m_flag[1], 7'b0, m_flag[0]};
      6'h10:   return m_rel[0];
      6'h14:   return m_val[0];
      6'h18:   return m_rel[1];
      6'h1C:   return m_val[1];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // per-cycle comparison, a quarter period after the active edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      check("R9 irq vs model", {30'b0, irq}, {30'b0, m_flag[1], m_flag[0]});
      check("R8 read vs model", rdata, mread(addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #(CLK_PERIOD/4);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high(input int ch, output int t);
    int guard = 0;
    do begin
      @(negedge clk); #1;
      guard++;
    end while (!irq[ch] && guard < 2000);
    t = cyc;
  endtask

  task automatic ref_pulse();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    idle(1);
  endtask

  task automatic report();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] v, v2;
    int t1, t2, seen;

    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    foreach (v2[i]) if (i < 0) v2 = 0;
    rd(6'h00, v); check("R1 ctrl", v, 0);
    rd(6'h04, v); check("R1 status", v, 0);
    rd(6'h10, v); check("R1 reload0", v, 0);
    rd(6'h14, v); check("R1 value0", v, 0);
    rd(6'h18, v); check("R1 reload1", v, 0);
    rd(6'h1C, v); check("R1 value1", v, 0);
    check("R1 irq", {30'b0, irq}, 0);

    // R2 control mask
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, v); check("R2 ctrl readback", v, 32'h01F8180F);
    wr(6'h00, 32'h0);
    wr(6'h04, 32'h0);
    rd(6'h04, v); check("R2 flags cleared", v, 0);

    // R4 periodic, reload 4 -> period 5 ticks
    wr(6'h10, 32'd4);
    wr(6'h14, 32'd4);
    wr(6'h04, 32'h0);
    wr(6'h00, 32'h3);
    wait_high(0, t1);
    wr(6'h04, 32'hFFFF_FFFE);
    wait_high(0, t2);
    check("R4 period", t2 - t1, 5);

    // R3 prescale exponent 2 -> period 20 cycles
    wr(6'h00, 32'h3 | (32'd2 << 19));
    wr(6'h04, 32'hFFFF_FFFE);
    wait_high(0, t1);
    wr(6'h04, 32'hFFFF_FFFE);
    wait_high(0, t2);
    check("R3 prescaled period", t2 - t1, 20);

    // R9 irq matches status word
    rd(6'h04, v); check("R9 irq vs status", {30'b0, irq}, {30'b0, v[8], v[0]});

    // R6 one-shot on channel 1 from the reference strobe; channel 0 stopped with flag set
    wait_high(0, t1);
    wr(6'h00, (32'd1 << 2) | (32'd1 << 12));
    wr(6'h1C, 32'd3);
    repeat (4) ref_pulse();
    check("R6 one-shot fired", {31'b0, irq[1]}, 1);
    rd(6'h1C, v); check("R6 parked at zero", v, 0);
    wr(6'h04, 32'hFFFF_FEFF);
    idle(1);
    check("R5 clear channel1", {31'b0, irq[1]}, 0);
    check("R5 channel0 untouched", {31'b0, irq[0]}, 1);
    repeat (5) ref_pulse();
    check("R6 no second event", {31'b0, irq[1]}, 0);
    rd(6'h1C, v); check("R6 still zero", v, 0);

    // R5 ones have no effect, then a zero clears
    wr(6'h04, 32'hFFFF_FFFF);
    idle(1);
    check("R5 ones ignored", {31'b0, irq[0]}, 1);
    wr(6'h04, 32'hFFFF_FFFE);
    idle(1);
    check("R5 zero clears", {31'b0, irq[0]}, 0);

    // R10 stopped channel keeps its value
    rd(6'h14, v); idle(10); rd(6'h14, v2);
    check("R10 stopped holds", v2, v);
    check("R10 no event", {31'b0, irq[0]}, 0);

    // R8 write priority while counting
    wr(6'h00, 32'h3);
    wr(6'h14, 32'h0000_1234);
    rd(6'h14, v); check("R8 written value", v, 32'h0000_1234);

    // R5 set wins over simultaneous clear
    wr(6'h14, 32'd2);
    seen = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      addr = 6'h04; we = 1'b1; wdata = 32'h0;
      #1 if (irq[0]) seen++;
    end
    @(negedge clk); we = 1'b0;
    check("R5 set wins", (seen > 0) ? 1 : 0, 1);

    // R7 free-running timestamp
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h14, v); idle(10); rd(6'h14, v2);
    check("R7 timestamp slope", (~v2) - (~v), 11);

    idle(3);
    report();
  end
endmodule